// File: doc/BRIEF.md
# Bundle Guard Pool Allocator

This block sits on the encode side of a wide instruction bundle whose functional slots are too narrow to hold a full guard register reference. Each bundle carries a shared pool of two guard entries, each holding a register index and an inversion bit. Every slot carries only a 2-bit selector. The allocator takes each slot's guard request in slot order, one per cycle. It places new (index, inversion) pairs into the pool and reuses an entry when a pair repeats. It emits the selector for each slot. It flags a hard error when a bundle needs a third distinct guard.

A bundle opens with a start pulse, which clears the pool. A close pulse returns the packed 10-bit pool field, every slot's selector and a validity verdict together, as a one-cycle done pulse. Packing these fields into the full bundle word is left to the surrounding encoder.

Top module: `guard_pool_alloc`

## Requirements
- R1: Synchronous active-high reset gives done=0, overflow=0, bundle_ok=0, pool_field=0 and every slot selector 3. A start pulse empties both pool entries, sets every slot selector of the new bundle to 3 (never), restarts slot numbering at slot 0 and clears the overflow flag.
- R2: A request of kind 0 (unconditional) is given selector 0 and does not occupy a pool entry.
- R3: A request of kind 2 or 3 (empty slot) is given selector 3 and does not occupy a pool entry.
- R4: A request of kind 1 (guarded) whose pair is not yet pooled fills entry 0 first (selector 1), then entry 1 (selector 2).
- R5: A guarded request whose (index, inversion) pair equals an occupied entry reuses that entry's selector. Pairs with the same index and a different inversion are distinct.
- R6: A guarded request with a third distinct pair is not placed and gets selector 3. The overflow output goes high on the clock edge that takes the request and stays high until the next start pulse.
- R7: The done output pulses high exactly on the cycle after a close pulse. With it, pool_field holds entry 0 index in bits [3:0], entry 0 inversion in bit 4, entry 1 index in bits [8:5] and entry 1 inversion in bit 9, with unused entries reading zero. slot_sel holds slot k's selector in bits [2k+1:2k], and slots are numbered in request order.
- R8: bundle_ok at done is 1 when no overflow occurred in the bundle and 0 otherwise.
- R9: Requests beyond the last slot (SLOTS) are ignored: they change no selector, no pool entry and no flag.
- R10: A request arriving with the start pulse becomes slot 0 of the new bundle. A request arriving with the close pulse is included in the reported bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bundle_start | input | 1 | Opens a new bundle, clears pool and flag |
| req_valid | input | 1 | One slot's guard request is present |
| req_kind | input | 2 | 0 unconditional, 1 guarded, 2/3 empty |
| req_idx | input | IDX_W | Guard register index |
| req_inv | input | 1 | Guard inversion bit |
| bundle_close | input | 1 | Requests the bundle result |
| done | output | 1 | Result valid pulse |
| pool_field | output | 2*(IDX_W+1) | Packed pool entries |
| slot_sel | output | 2*SLOTS | Per-slot selectors |
| bundle_ok | output | 1 | Bundle encoded without overflow |
| overflow | output | 1 | Sticky overflow flag for the open bundle |

## Verification
Every result is due one clock edge after the input that causes it. The overflow flag reflects a request from the edge that takes it. The done pulse, the pool field, the selectors and the verdict all appear on the edge that takes the close. The bench drives each input on a falling edge and lets one rising edge pass. It then samples on the next falling edge against a model it updates at that same rising edge. Same-cycle start-with-request and close-with-request cases sit inside that one-edge window. Out-of-range slots are checked through the reported selectors and flags.

// File: rtl/guard_pool_pkg.sv
package guard_pool_pkg;

  typedef enum logic [1:0] {
    KIND_ALWAYS = 2'd0,
    KIND_GUARD  = 2'd1,
    KIND_EMPTY  = 2'd2,
    KIND_EMPTY2 = 2'd3
  } req_kind_e;

  localparam logic [1:0] SEL_ALWAYS = 2'd0;
  localparam logic [1:0] SEL_P0     = 2'd1;
  localparam logic [1:0] SEL_P1     = 2'd2;
  localparam logic [1:0] SEL_NEVER  = 2'd3;

  localparam int POOL_ENTRIES = 2;

  // selector that refers to pool entry e
  function automatic logic [1:0] entry_sel(input logic which);
    return which ? SEL_P1 : SEL_P0;
  endfunction

endpackage

// File: rtl/pool_match.sv
module pool_match #(
  parameter int IDX_W   = 4,
  parameter int ENTRIES = 2
) (
  input  logic [ENTRIES-1:0]       e_vld,
  input  logic [ENTRIES*IDX_W-1:0] e_idx,
  input  logic [ENTRIES-1:0]       e_inv,
  input  logic [IDX_W-1:0]         q_idx,
  input  logic                     q_inv,
  output logic [ENTRIES-1:0]       hit,
  output logic [ENTRIES-1:0]       first_free
);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit[g] = e_vld[g] && (e_idx[g*IDX_W +: IDX_W] == q_idx) && (e_inv[g] == q_inv);
    end
  endgenerate

  // lowest-numbered empty entry, one-hot
  always_comb begin
    logic seen;
    seen = 1'b0;
    first_free = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!e_vld[e] && !seen) begin
        first_free[e] = 1'b1;
        seen = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sel_bank.sv
module sel_bank #(
  parameter int SLOTS = 8,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_slot,
  input  logic [1:0]         wr_sel,
  output logic [2*SLOTS-1:0] nxt_vec
);
  import guard_pool_pkg::*;

  logic [2*SLOTS-1:0] cur;

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      assign nxt_vec[2*s +: 2] = (wr_en && wr_slot == AW'(s)) ? wr_sel :
                                 (clear ? SEL_NEVER : cur[2*s +: 2]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cur <= '1;
    else     cur <= nxt_vec;
  end

endmodule

// File: rtl/guard_pool_alloc.sv
module guard_pool_alloc #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bundle_start,
  input  logic                       req_valid,
  input  logic [1:0]                 req_kind,
  input  logic [IDX_W-1:0]           req_idx,
  input  logic                       req_inv,
  input  logic                       bundle_close,
  output logic                       done,
  output logic [2*(IDX_W+1)-1:0]     pool_field,
  output logic [2*SLOTS-1:0]         slot_sel,
  output logic                       bundle_ok,
  output logic                       overflow
);
  import guard_pool_pkg::*;

  localparam int ENT   = POOL_ENTRIES;
  localparam int EW    = IDX_W + 1;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // pool state
  logic [ENT-1:0]       e_vld;
  logic [ENT*IDX_W-1:0] e_idx;
  logic [ENT-1:0]       e_inv;
  logic [CNT_W-1:0]     cnt;
  logic                 err;

  // state after an optional start pulse
  logic [ENT-1:0]       b_vld;
  logic [ENT*IDX_W-1:0] b_idx;
  logic [ENT-1:0]       b_inv;
  logic [CNT_W-1:0]     b_cnt;
  logic                 b_err;

  // next state
  logic [ENT-1:0]       n_vld;
  logic [ENT*IDX_W-1:0] n_idx;
  logic [ENT-1:0]       n_inv;
  logic [CNT_W-1:0]     n_cnt;
  logic                 n_err;

  logic [ENT-1:0]       hit;
  logic [ENT-1:0]       free1h;
  logic                 wr_en;
  logic [1:0]           wr_sel;
  logic [AW-1:0]        wr_slot;
  logic [2*SLOTS-1:0]   sel_nxt;
  logic [2*EW-1:0]      field_nxt;
  req_kind_e            kind;

  assign kind  = req_kind_e'(req_kind);
  assign b_vld = bundle_start ? '0 : e_vld;
  assign b_idx = bundle_start ? '0 : e_idx;
  assign b_inv = bundle_start ? '0 : e_inv;
  assign b_cnt = bundle_start ? '0 : cnt;
  assign b_err = bundle_start ? 1'b0 : err;

  pool_match #(.IDX_W(IDX_W), .ENTRIES(ENT)) u_match (
    .e_vld      (b_vld),
    .e_idx      (b_idx),
    .e_inv      (b_inv),
    .q_idx      (req_idx),
    .q_inv      (req_inv),
    .hit        (hit),
    .first_free (free1h)
  );

  always_comb begin
    n_vld   = b_vld;
    n_idx   = b_idx;
    n_inv   = b_inv;
    n_cnt   = b_cnt;
    n_err   = b_err;
    wr_en   = 1'b0;
    wr_sel  = SEL_NEVER;
    wr_slot = AW'(b_cnt);
    if (req_valid && (b_cnt < CNT_W'(SLOTS))) begin
      wr_en = 1'b1;
      n_cnt = b_cnt + 1'b1;
      unique case (kind)
        KIND_ALWAYS: wr_sel = SEL_ALWAYS;
        KIND_GUARD: begin
          if (|hit) begin
            wr_sel = entry_sel(hit[1]);
          end else if (|free1h) begin
            for (int e = 0; e < ENT; e++) begin
              if (free1h[e]) begin
                n_vld[e]                 = 1'b1;
                n_idx[e*IDX_W +: IDX_W]  = req_idx;
                n_inv[e]                 = req_inv;
              end
            end
            wr_sel = entry_sel(free1h[1]);
          end else begin
            wr_sel = SEL_NEVER;
            n_err  = 1'b1;
          end
        end
        default: wr_sel = SEL_NEVER;
      endcase
    end
  end

  sel_bank #(.SLOTS(SLOTS), .AW(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .clear   (bundle_start),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_sel  (wr_sel),
    .nxt_vec (sel_nxt)
  );

  genvar g;
  generate
    for (g = 0; g < ENT; g++) begin : g_pack
      assign field_nxt[g*EW +: EW] = {n_inv[g], n_idx[g*IDX_W +: IDX_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld <= '0;
      e_idx <= '0;
      e_inv <= '0;
      cnt   <= '0;
      err   <= 1'b0;
    end else begin
      e_vld <= n_vld;
      e_idx <= n_idx;
      e_inv <= n_inv;
      cnt   <= n_cnt;
      err   <= n_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      pool_field <= '0;
      slot_sel   <= '1;
      bundle_ok  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      done     <= bundle_close;
      overflow <= n_err;
      if (bundle_close) begin
        pool_field <= field_nxt;
        slot_sel   <= sel_nxt;
        bundle_ok  <= !n_err;
      end
    end
  end

  // ---------------- assertions ----------------
  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    bundle_start |=> !overflow);

  p_fill_order_r4: assert property (@(posedge clk) disable iff (rst)
    e_vld[1] |-> e_vld[0]);

  p_distinct_entries_r5: assert property (@(posedge clk) disable iff (rst)
    (&e_vld) |-> ({e_inv[0], e_idx[0 +: IDX_W]} != {e_inv[1], e_idx[IDX_W +: IDX_W]}));

  p_single_hit_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  p_sticky_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (overflow && !bundle_start) |=> overflow);

  p_done_follows_close_r7: assert property (@(posedge clk) disable iff (rst)
    bundle_close |=> done);

  p_done_is_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !bundle_close |=> !done);

  p_ok_vs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (bundle_ok == !overflow));

endmodule

// File: tb/guard_pool_alloc_test.sv
`timescale 1ns/1ps
module guard_pool_alloc_test;
  localparam int SLOTS = 8;
  localparam int IDX_W = 4;
  localparam int FW    = 2 * (IDX_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bundle_start = 1'b0, req_valid = 1'b0, req_inv = 1'b0, bundle_close = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [IDX_W-1:0] req_idx = '0;
  logic done, bundle_ok, overflow;
  logic [FW-1:0] pool_field;
  logic [2*SLOTS-1:0] slot_sel;

  always #4 clk = ~clk;   // 125 MHz

  guard_pool_alloc #(.SLOTS(SLOTS), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .bundle_start(bundle_start), .req_valid(req_valid),
    .req_kind(req_kind), .req_idx(req_idx), .req_inv(req_inv),
    .bundle_close(bundle_close), .done(done), .pool_field(pool_field),
    .slot_sel(slot_sel), .bundle_ok(bundle_ok), .overflow(overflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model
  logic             m_vld [2];
  logic [IDX_W-1:0] m_idx [2];
  logic             m_inv [2];
  logic [1:0]       m_sel [SLOTS];
  int               m_cnt;
  logic             m_err;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] exp_field();
    logic [FW-1:0] f;
    f = '0;
    for (int e = 0; e < 2; e++)
      if (m_vld[e]) f[e*(IDX_W+1) +: IDX_W+1] = {m_inv[e], m_idx[e]};
    return f;
  endfunction

  function automatic logic [2*SLOTS-1:0] exp_sels();
    logic [2*SLOTS-1:0] v;
    for (int s = 0; s < SLOTS; s++) v[2*s +: 2] = m_sel[s];
    return v;
  endfunction

  task automatic model_clear();
    for (int e = 0; e < 2; e++) begin m_vld[e] = 0; m_idx[e] = '0; m_inv[e] = 0; end
    for (int s = 0; s < SLOTS; s++) m_sel[s] = 2'd3;
    m_cnt = 0;
    m_err = 0;
  endtask

  task automatic model_req(input logic [1:0] kd, input logic [IDX_W-1:0] ix, input logic iv);
    logic [1:0] sel;
    if (m_cnt >= SLOTS) return;   // R9
    if (kd == 2'd0) sel = 2'd0;
    else if (kd != 2'd1) sel = 2'd3;
    else if (m_vld[0] && m_idx[0] == ix && m_inv[0] == iv) sel = 2'd1;
    else if (m_vld[1] && m_idx[1] == ix && m_inv[1] == iv) sel = 2'd2;
    else if (!m_vld[0]) begin m_vld[0] = 1; m_idx[0] = ix; m_inv[0] = iv; sel = 2'd1; end
    else if (!m_vld[1]) begin m_vld[1] = 1; m_idx[1] = ix; m_inv[1] = iv; sel = 2'd2; end
    else begin sel = 2'd3; m_err = 1; end
    m_sel[m_cnt] = sel;
    m_cnt++;
  endtask

  // one cycle: drive at falling edge, model at rising edge, check at next falling edge
  task automatic step(input logic st, input logic rv, input logic [1:0] kd,
                      input logic [IDX_W-1:0] ix, input logic iv, input logic cl,
                      input string tag);
    bundle_start = st; req_valid = rv; req_kind = kd; req_idx = ix; req_inv = iv;
    bundle_close = cl;
    @(posedge clk);
    if (st) model_clear();
    if (rv) model_req(kd, ix, iv);
    @(negedge clk);
    bundle_start = 0; req_valid = 0; bundle_close = 0;
    chk({tag, " R6 overflow"}, 64'(overflow), 64'(m_err));
    chk({tag, " R7 done"}, 64'(done), 64'(cl));
    if (cl) begin
      chk({tag, " R7 pool_field"}, 64'(pool_field), 64'(exp_field()));
      chk({tag, " R7 slot_sel"}, 64'(slot_sel), 64'(exp_sels()));
      chk({tag, " R8 bundle_ok"}, 64'(bundle_ok), 64'(!m_err));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 reset done", 64'(done), 0);
    chk("R1 reset overflow", 64'(overflow), 0);
    chk("R1 reset bundle_ok", 64'(bundle_ok), 0);
    chk("R1 reset pool_field", 64'(pool_field), 0);
    chk("R1 reset slot_sel", 64'(slot_sel), 64'({2*SLOTS{1'b1}}));

    // directed bundle: R10 start with request, R2..R6
    step(1, 1, 2'd0, 4'd0, 0, 0, "R10 start+req R2");
    step(0, 1, 2'd1, 4'd5, 0, 0, "R4 first");
    step(0, 1, 2'd1, 4'd5, 0, 0, "R5 dedup");
    step(0, 1, 2'd1, 4'd5, 1, 0, "R5 inv distinct");
    step(0, 1, 2'd2, 4'd9, 1, 0, "R3 empty");
    step(0, 1, 2'd3, 4'd9, 1, 0, "R3 empty3");
    step(0, 1, 2'd1, 4'd9, 0, 0, "R6 third");
    step(0, 0, 2'd0, 4'd0, 0, 0, "R6 sticky");
    step(0, 1, 2'd1, 4'd5, 1, 1, "R10 close+req R8");
    chk("R5 slot3 sel P1", 64'(slot_sel[7:6]), 2);
    chk("R6 slot6 sel never", 64'(slot_sel[13:12]), 3);
    chk("R7 field", 64'(pool_field), 64'({1'b1, 4'd5, 1'b0, 4'd5}));
    step(0, 0, 2'd0, 4'd0, 0, 0, "R7 done pulse");

    // R1 start clears flag; R9 overflow of slot count
    step(1, 0, 2'd0, 4'd0, 0, 0, "R1 start clears");
    for (int i = 0; i < SLOTS; i++) step(0, 1, 2'd1, 4'(i % 2), 0, 0, "R4 fill");
    step(0, 1, 2'd1, 4'd12, 1, 0, "R9 beyond last");
    step(0, 1, 2'd0, 4'd0, 0, 1, "R9 close");
    chk("R9 no overflow", 64'(overflow), 0);
    chk("R9 bundle_ok", 64'(bundle_ok), 1);

    // empty bundle
    step(1, 0, 2'd0, 4'd0, 0, 1, "R1 empty bundle");

    // constrained random bundles
    for (int b = 0; b < 400; b++) begin
      int len;
      len = $urandom_range(0, SLOTS + 2);
      step(1, $urandom_range(0, 1), 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 0, "RND start");
      for (int k = 0; k < len; k++)
        step(0, $urandom_range(0, 4) != 0, 2'($urandom_range(0, 3)),
             4'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             (k == len - 1) && $urandom_range(0, 1) == 1, "RND req");
      step(0, $urandom_range(0, 1), 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1, "RND close");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule